// File: doc/BRIEF.md
# Dispatch Stage Width Controller

This block sits between decode and the out-of-order back end and decides, every clock, which of the decoded instructions presented in program order may be dispatched. Each clock is one dispatch cycle with a budget of micro-op slots equal to the dispatch width. Up to `LANES` candidates arrive in parallel, lane 0 being the oldest. Each candidate carries its micro-op count, an ID, a rename-capacity mask (one bit per register file that cannot take its writes), and a scheduler status code. A single count of free retire-queue entries is shared by all lanes.

Candidates are accepted strictly in order. An instruction whose micro-op count exceeds the width may only enter a group with the whole budget free. It then takes the whole group, and the excess is carried over to block later cycles. The first refused candidate is reported with a typed stall reason and its ID. Each accepted candidate raises a per-lane fire pulse with its ID, which drives the rename-allocate and retire-reserve requests downstream.

Top module: `dsw_ctrl`

## Requirements
- R1: After reset the budget (`slots_left`) equals the width (4 by default), `carry_pending` is 0, and no lane fires or stalls while no lane is valid.
- R2: Lane i fires only if every lane below it fired in the same cycle. An invalid lane ends the group without a stall report.
- R3: A candidate whose micro-op count (at most the width) fits in the remaining slots fires, and its count is subtracted for the lanes above it. A candidate that does not fit is refused with reason code 7 (width).
- R4: A candidate with more micro-ops than the width fires only in lane 0 with the full budget. Otherwise it is refused with code 7. After it fires, the next cycle's budget is the width minus the excess, clamped at 0. The excess left is the excess minus the width, clamped at 0.
- R5: While carry-over is pending (`carry_pending` = 1), nothing fires and a valid lane 0 is refused with code 7. Lanes above a fired wide candidate in the same cycle are also refused with code 7.
- R6: A nonzero rename-capacity mask refuses the candidate with code 1 (register file).
- R7: Retire space is consumed cumulatively across lanes in a cycle. A candidate needs its micro-op count, or one entry if the count is 0. A candidate that does not fit in what is left of `retire_free` is refused with code 2 (retire).
- R8: Scheduler status 0 is available. Status 1 refuses with code 3 (issue queue), 2 with code 4 (load queue), 3 with code 5 (store queue), and 4 through 7 with code 6 (group restriction).
- R9: The checks are applied in this order: carry-over, rename, retire, scheduler, slot fit. Only the first refused lane is reported, through `stall_valid`, `stall_reason` and `stall_id`. `stall_reason` is 0 when `stall_valid` is 0.
- R10: `disp_id` carries the candidate's ID in each fired lane and zero in every other lane.
- R11: In a cycle with no carry-over pending and no wide candidate fired, the next cycle's budget returns to the full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one dispatch cycle per edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | LANES | Candidate present per lane |
| in_uops | input | LANES*UOP_W | Micro-op count per lane |
| in_id | input | LANES*ID_W | Instruction ID per lane |
| in_rf_busy | input | LANES*RF_CNT | Rename-capacity mask per lane (nonzero = no room) |
| in_sched | input | LANES*3 | Scheduler status code per lane |
| retire_free | input | RET_W | Free retire-queue entries this cycle |
| disp_fire | output | LANES | Per-lane dispatch-accepted pulse |
| disp_id | output | LANES*ID_W | ID of each fired lane, zero otherwise |
| stall_valid | output | 1 | A candidate was refused this cycle |
| stall_reason | output | 3 | Stall reason code of the first refused lane |
| stall_id | output | ID_W | ID of the first refused lane |
| slots_left | output | UOP_W | Slot budget at the start of this cycle |
| carry_pending | output | 1 | Carry-over from a wide instruction is still draining |

## Verification
On every cycle the assertions check the following: the fire vector stays contiguous from lane 0, nothing fires under carry-over, at most one lane is refused, the budget never exceeds the width, the carry drains strictly, and non-fired lanes show a zero ID. The directed scenarios cover the rest. These are the numeric values of the budget after a wide instruction, the cumulative retire accounting with zero-micro-op candidates, the mapping from each scheduler code to its stall code, and the priority between simultaneous refusal causes. Only known stimulus with computed expectations can show these.

// File: rtl/dsw_pkg.sv
// Package: shared stall-reason type and scheduler-code mapping for the
// dispatch width controller. Assumes a 3-bit scheduler status code.
package dsw_pkg;

    typedef enum logic [2:0] {
        STALL_NONE    = 3'd0,
        STALL_REGFILE = 3'd1,
        STALL_RETIRE  = 3'd2,
        STALL_ISSUEQ  = 3'd3,
        STALL_LOADQ   = 3'd4,
        STALL_STOREQ  = 3'd5,
        STALL_GROUP   = 3'd6,
        STALL_WIDTH   = 3'd7
    } stall_e;

    localparam logic [2:0] SCH_AVAIL  = 3'd0;
    localparam logic [2:0] SCH_ISSUEQ = 3'd1;
    localparam logic [2:0] SCH_LOADQ  = 3'd2;
    localparam logic [2:0] SCH_STOREQ = 3'd3;

    // Map a non-available scheduler code onto its stall reason.
    function automatic stall_e sched_to_stall(input logic [2:0] code);
        case (code)
            SCH_ISSUEQ: return STALL_ISSUEQ;
            SCH_LOADQ:  return STALL_LOADQ;
            SCH_STOREQ: return STALL_STOREQ;
            default:    return STALL_GROUP;
        endcase
    endfunction

endpackage

// File: rtl/dsw_lane_check.sv
// Module: per-lane dispatch decision. Combinational.
// Applies, in priority order, the carry-over, rename, retire, scheduler and
// slot-fit checks to one candidate. It forwards the remaining slot budget,
// the remaining retire space and the carry-block flag to the next lane.
// Assumes en_in is high only when every older lane fired.
module dsw_lane_check
    import dsw_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter int UOP_W  = 4,
    parameter int RF_CNT = 2,
    parameter int RET_W  = 5
) (
    input  logic              en_in,
    input  logic              valid,
    input  logic [UOP_W-1:0]  uops,
    input  logic [RF_CNT-1:0] rf_busy,
    input  logic [2:0]        sched,
    input  logic [UOP_W-1:0]  slots_in,
    input  logic              carry_in,
    input  logic [RET_W-1:0]  retire_in,
    output logic              fire,
    output logic              refuse,
    output stall_e            reason,
    output logic [UOP_W-1:0]  slots_out,
    output logic              carry_out,
    output logic [RET_W-1:0]  retire_out,
    output logic [UOP_W-1:0]  wide_amt
);
    localparam logic [UOP_W-1:0] WIDTH_U = UOP_W'(WIDTH);

    logic [UOP_W-1:0] need;
    logic [RET_W:0]   need_ext;
    logic             is_wide;

    // Retire entries needed: zero-micro-op instructions still take one entry.
    always_comb begin
        need     = (uops == '0) ? UOP_W'(1) : uops;
        need_ext = (RET_W+1)'(need);
        is_wide  = (uops > WIDTH_U);
    end

    // Priority-ordered accept/refuse decision for this lane.
    always_comb begin
        fire   = 1'b0;
        refuse = 1'b0;
        reason = STALL_NONE;
        if (en_in && valid) begin
            if (carry_in) begin
                refuse = 1'b1;
                reason = STALL_WIDTH;
            end else if (rf_busy != '0) begin
                refuse = 1'b1;
                reason = STALL_REGFILE;
            end else if ({1'b0, retire_in} < need_ext) begin
                refuse = 1'b1;
                reason = STALL_RETIRE;
            end else if (sched != SCH_AVAIL) begin
                refuse = 1'b1;
                reason = sched_to_stall(sched);
            end else if (is_wide) begin
                if (slots_in == WIDTH_U) begin
                    fire = 1'b1;
                end else begin
                    refuse = 1'b1;
                    reason = STALL_WIDTH;
                end
            end else if (uops <= slots_in) begin
                fire = 1'b1;
            end else begin
                refuse = 1'b1;
                reason = STALL_WIDTH;
            end
        end
    end

    // Budget, retire space and carry state handed to the next lane.
    always_comb begin
        slots_out  = slots_in;
        retire_out = retire_in;
        carry_out  = carry_in;
        wide_amt   = '0;
        if (fire) begin
            retire_out = retire_in - need_ext[RET_W-1:0];
            if (is_wide) begin
                slots_out = '0;
                carry_out = 1'b1;
                wide_amt  = uops - WIDTH_U;
            end else begin
                slots_out = slots_in - uops;
            end
        end
    end

endmodule

// File: rtl/dsw_budget.sv
// Module: per-cycle slot budget and carry-over register.
// At each clock edge it folds in any excess from a wide instruction fired
// this cycle. It then reloads the budget as width minus carry and drains
// the carry by one width, both clamped at zero.
// Assumes wide_amt is nonzero only when a wide instruction fired.
module dsw_budget #(
    parameter int WIDTH = 4,
    parameter int UOP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [UOP_W-1:0] wide_amt,
    output logic [UOP_W-1:0] slots_q,
    output logic [UOP_W-1:0] carry_q
);
    localparam logic [UOP_W-1:0] WIDTH_U = UOP_W'(WIDTH);

    logic [UOP_W-1:0] carry_mid;
    logic [UOP_W-1:0] slots_n;
    logic [UOP_W-1:0] carry_n;

    // Cycle-boundary arithmetic with saturation at zero.
    always_comb begin
        carry_mid = (carry_q != '0) ? carry_q : wide_amt;
        slots_n   = (carry_mid >= WIDTH_U) ? '0 : WIDTH_U - carry_mid;
        carry_n   = (carry_mid > WIDTH_U) ? carry_mid - WIDTH_U : '0;
    end

    // Budget and carry state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots_q <= WIDTH_U;
            carry_q <= '0;
        end else begin
            slots_q <= slots_n;
            carry_q <= carry_n;
        end
    end

    p_slots_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        slots_q <= WIDTH_U);

    p_carry_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_q != '0) |=> (carry_q < $past(carry_q)));

    p_refresh_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_q == '0 && wide_amt == '0) |=> (slots_q == WIDTH_U));

endmodule

// File: rtl/dsw_stall_pick.sv
// Module: merges the per-lane refusals into one stall report.
// Assumes at most one lane refuses per cycle, which the in-order lane
// chain guarantees, so an OR merge of gated fields is exact.
module dsw_stall_pick #(
    parameter int LANES = 4,
    parameter int ID_W  = 6
) (
    input  logic [LANES-1:0]      refuse,
    input  logic [LANES*3-1:0]    reasons,
    input  logic [LANES*ID_W-1:0] ids,
    output logic                  stall_valid,
    output logic [2:0]            stall_reason,
    output logic [ID_W-1:0]       stall_id
);
    // OR-merge the reason and ID of the refusing lane.
    always_comb begin
        stall_valid  = |refuse;
        stall_reason = '0;
        stall_id     = '0;
        for (int i = 0; i < LANES; i++) begin
            if (refuse[i]) begin
                stall_reason = stall_reason | reasons[i*3 +: 3];
                stall_id     = stall_id | ids[i*ID_W +: ID_W];
            end
        end
    end

endmodule

// File: rtl/dsw_ctrl.sv
// Module: dispatch stage width controller (top).
// Chains one lane checker per candidate in program order. It feeds the
// chain from the registered slot budget and carry-over, and reports the
// fire pulses and the first stall. Assumes lane 0 holds the oldest
// candidate and that retire_free counts the entries free this cycle.
module dsw_ctrl
    import dsw_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int WIDTH  = 4,
    parameter int UOP_W  = 4,
    parameter int ID_W   = 6,
    parameter int RF_CNT = 2,
    parameter int RET_W  = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        in_valid,
    input  logic [LANES*UOP_W-1:0]  in_uops,
    input  logic [LANES*ID_W-1:0]   in_id,
    input  logic [LANES*RF_CNT-1:0] in_rf_busy,
    input  logic [LANES*3-1:0]      in_sched,
    input  logic [RET_W-1:0]        retire_free,
    output logic [LANES-1:0]        disp_fire,
    output logic [LANES*ID_W-1:0]   disp_id,
    output logic                    stall_valid,
    output logic [2:0]              stall_reason,
    output logic [ID_W-1:0]         stall_id,
    output logic [UOP_W-1:0]        slots_left,
    output logic                    carry_pending
);
    logic [UOP_W-1:0] slots_q;
    logic [UOP_W-1:0] carry_q;
    logic [UOP_W-1:0] wide_any;

    logic [LANES:0]   en_c;
    logic [LANES:0]   carry_c;
    logic [UOP_W-1:0] slots_c  [LANES+1];
    logic [RET_W-1:0] retire_c [LANES+1];
    logic [UOP_W-1:0] wide_l   [LANES];
    logic [LANES-1:0] refuse;
    logic [LANES*3-1:0] reasons;

    // Seed the lane chain from the registered state and the retire count.
    always_comb begin
        en_c[0]     = 1'b1;
        carry_c[0]  = (carry_q != '0);
        slots_c[0]  = slots_q;
        retire_c[0] = retire_free;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        stall_e reason_l;

        dsw_lane_check #(
            .WIDTH(WIDTH), .UOP_W(UOP_W), .RF_CNT(RF_CNT), .RET_W(RET_W)
        ) u_lane (
            .en_in     (en_c[g]),
            .valid     (in_valid[g]),
            .uops      (in_uops[g*UOP_W +: UOP_W]),
            .rf_busy   (in_rf_busy[g*RF_CNT +: RF_CNT]),
            .sched     (in_sched[g*3 +: 3]),
            .slots_in  (slots_c[g]),
            .carry_in  (carry_c[g]),
            .retire_in (retire_c[g]),
            .fire      (disp_fire[g]),
            .refuse    (refuse[g]),
            .reason    (reason_l),
            .slots_out (slots_c[g+1]),
            .carry_out (carry_c[g+1]),
            .retire_out(retire_c[g+1]),
            .wide_amt  (wide_l[g])
        );

        // Gate this lane's enable, reason and outgoing ID.
        always_comb begin
            en_c[g+1]                = disp_fire[g];
            reasons[g*3 +: 3]        = reason_l;
            disp_id[g*ID_W +: ID_W]  = disp_fire[g] ? in_id[g*ID_W +: ID_W] : '0;
        end

        if (g > 0) begin : g_order
            p_in_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
                disp_fire[g] |-> disp_fire[g-1]);
        end

        p_id_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !disp_fire[g] |-> (disp_id[g*ID_W +: ID_W] == '0));
    end

    // Collect the excess of the one wide instruction that may fire.
    always_comb begin
        wide_any = '0;
        for (int i = 0; i < LANES; i++) wide_any = wide_any | wide_l[i];
    end

    dsw_budget #(.WIDTH(WIDTH), .UOP_W(UOP_W)) u_budget (
        .clk     (clk),
        .rst_n   (rst_n),
        .wide_amt(wide_any),
        .slots_q (slots_q),
        .carry_q (carry_q)
    );

    dsw_stall_pick #(.LANES(LANES), .ID_W(ID_W)) u_pick (
        .refuse      (refuse),
        .reasons     (reasons),
        .ids         (in_id),
        .stall_valid (stall_valid),
        .stall_reason(stall_reason),
        .stall_id    (stall_id)
    );

    // Expose the budget state at the start of the cycle.
    always_comb begin
        slots_left    = slots_q;
        carry_pending = (carry_q != '0);
    end

    p_no_fire_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        carry_pending |-> (disp_fire == '0));

    p_one_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(refuse));

    p_reason_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stall_valid |-> (stall_reason != 3'd0));

endmodule

// File: tb/sim_dsw_ctrl.sv
module sim_dsw_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int L  = 4;
    localparam int UW = 4;
    localparam int IW = 6;
    localparam int RF = 2;
    localparam int RW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [L-1:0]    v = '0;
    logic [L*UW-1:0] u = '0;
    logic [L*IW-1:0] id = '0;
    logic [L*RF-1:0] rf = '0;
    logic [L*3-1:0]  sc = '0;
    logic [RW-1:0]   rfree = 5'd31;

    logic [L-1:0]    fire;
    logic [L*IW-1:0] did;
    logic            st_v;
    logic [2:0]      st_r;
    logic [IW-1:0]   st_id;
    logic [UW-1:0]   slots;
    logic            carry;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsw_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(v), .in_uops(u), .in_id(id),
        .in_rf_busy(rf), .in_sched(sc), .retire_free(rfree),
        .disp_fire(fire), .disp_id(did), .stall_valid(st_v),
        .stall_reason(st_r), .stall_id(st_id), .slots_left(slots),
        .carry_pending(carry)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_lanes();
        v = '0; u = '0; id = '0; rf = '0; sc = '0; rfree = 5'd31;
    endtask

    task automatic lane(input int i, input int uops, input int ident,
                        input int rfm, input int sch);
        v[i] = 1'b1;
        u[i*UW +: UW] = UW'(uops);
        id[i*IW +: IW] = IW'(ident);
        rf[i*RF +: RF] = RF'(rfm);
        sc[i*3 +: 3] = 3'(sch);
    endtask

    // Advance one cycle: inputs change on the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        clear_lanes();
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_reset();
        settle();
        chk("R1 slots", int'(slots), 4);
        chk("R1 carry", int'(carry), 0);
        chk("R1 fire", int'(fire), 0);
        chk("R1 stall", int'(st_v), 0);
        chk("R9 idle reason", int'(st_r), 0);
        step();
    endtask

    task automatic t_fit();
        lane(0, 1, 10, 0, 0); lane(1, 2, 11, 0, 0);
        lane(2, 1, 12, 0, 0); lane(3, 1, 13, 0, 0);
        settle();
        chk("R3 fire", int'(fire), 4'b0111);
        chk("R3 reason", int'(st_r), 7);
        chk("R9 stall id", int'(st_id), 13);
        chk("R10 id lane1", int'(did[1*IW +: IW]), 11);
        chk("R10 id lane3 zero", int'(did[3*IW +: IW]), 0);
        step();
        settle();
        chk("R11 refresh", int'(slots), 4);
    endtask

    task automatic t_gap();
        lane(0, 1, 20, 0, 0); lane(2, 1, 22, 0, 0);
        settle();
        chk("R2 fire", int'(fire), 4'b0001);
        chk("R2 no stall", int'(st_v), 0);
        step();
    endtask

    task automatic t_wide();
        lane(0, 6, 30, 0, 0); lane(1, 0, 31, 0, 0);
        settle();
        chk("R4 wide fire", int'(fire), 4'b0001);
        chk("R5 after wide", int'(st_r), 7);
        chk("R5 after wide id", int'(st_id), 31);
        step();
        settle();
        chk("R4 next slots", int'(slots), 2);
        chk("R4 next carry", int'(carry), 0);
        lane(0, 2, 32, 0, 0); lane(1, 1, 33, 0, 0);
        settle();
        chk("R3 reduced fire", int'(fire), 4'b0001);
        chk("R3 reduced reason", int'(st_r), 7);
        step();
        settle();
        chk("R11 back to full", int'(slots), 4);
    endtask

    task automatic t_wide_late();
        lane(0, 1, 40, 0, 0); lane(1, 5, 41, 0, 0);
        settle();
        chk("R4 not first fire", int'(fire), 4'b0001);
        chk("R4 not first reason", int'(st_r), 7);
        chk("R4 not first id", int'(st_id), 41);
        step();
    endtask

    task automatic t_long();
        lane(0, 10, 50, 0, 0);
        settle();
        chk("R4 long fire", int'(fire), 1);
        step();
        settle();
        chk("R4 long slots", int'(slots), 0);
        chk("R5 carry pending", int'(carry), 1);
        lane(0, 0, 51, 1, 0);
        settle();
        chk("R5 blocked fire", int'(fire), 0);
        chk("R9 carry over rename", int'(st_r), 7);
        step();
        settle();
        chk("R4 drained slots", int'(slots), 2);
        chk("R4 drained carry", int'(carry), 0);
        lane(0, 3, 52, 0, 0);
        settle();
        chk("R3 too big", int'(st_r), 7);
        chk("R3 too big fire", int'(fire), 0);
        step();
    endtask

    task automatic t_rename();
        lane(0, 1, 60, 2, 1);
        settle();
        chk("R6 fire", int'(fire), 0);
        chk("R6 reason", int'(st_r), 1);
        chk("R6 id", int'(st_id), 60);
        step();
    endtask

    task automatic t_retire();
        lane(0, 2, 1, 0, 0); lane(1, 0, 2, 0, 0); lane(2, 1, 3, 0, 1);
        rfree = 5'd3;
        settle();
        chk("R7 fire", int'(fire), 4'b0011);
        chk("R7 reason over sched", int'(st_r), 2);
        chk("R7 id", int'(st_id), 3);
        step();
    endtask

    task automatic t_sched();
        for (int c = 1; c < 8; c++) begin
            lane(0, 1, 7, 0, c);
            settle();
            chk("R8 code map", int'(st_r), (c < 4) ? c + 2 : 6);
            chk("R8 no fire", int'(fire), 0);
            step();
        end
        lane(0, 1, 8, 0, 0); lane(1, 5, 9, 0, 2);
        settle();
        chk("R9 sched over width", int'(st_r), 4);
        chk("R9 fire", int'(fire), 1);
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fit();
        t_gap();
        t_wide();
        t_wide_late();
        t_long();
        t_rename();
        t_retire();
        t_sched();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule